// File: doc/BRIEF.md
# Bus break-condition match channel

One hardware break channel that watches a processor's bus cycles. Software loads a control word, a match address, a match data value, a data mask and a data-condition word through a small register port. On every observed bus cycle the channel checks the cycle against all enabled conditions. These are the cycle type (instruction fetch or operand access), the transfer direction, the bus selection, an exact address match and, when enabled, an operand size together with a masked data comparison. When every condition holds, the channel raises a one-clock break request and sets a sticky match flag.

A quadword operand access carries 64 bits of data. With data comparison enabled, each 32-bit half is compared against the single masked match value, and the data condition is met if either half matches. The channel resets disabled. While its enable bit is clear it ignores all other settings.

Top module: `brk_match_chan`

## Requirements
- R1: After synchronous reset all registers read 0, and brk_req and hit_flag are 0.
- R2: Control register (index 0) layout: bit 0 enable, bits 2:1 direction select, bit 3 reserved, bits 5:4 cycle-type select, bits 7:6 bus select. Bit 3 and bits 31:8 always read back 0. The match address (index 1), match data (index 2), data mask (index 3) and data-condition word (index 4) read back what was written. The data-condition word keeps only bits 2:0.
- R3: With control bit 0 at 0, no bus cycle ever produces a break request, whatever the other settings.
- R4: Cycle-type select: 01 accepts only fetches (obs_fetch=1), 10 accepts only operand accesses (obs_fetch=0), and 00 and 11 accept both.
- R5: Direction select applies only when cycle-type select is 10. In that case 01 accepts only reads (obs_write=0), 10 accepts only writes, and 00 and 11 accept both. Under any other cycle-type select, direction is ignored.
- R6: Bus select applies only when cycle-type select is 10. In that case only 00 (operand bus) can match, and 01, 10 and 11 never match. Under any other cycle-type select, bus select is ignored.
- R7: A cycle matches only if obs_addr equals the match address on every bit.
- R8: Data-condition word bit 0 enables data comparison. Bits 2:1 then name the required operand size: 0 byte, 1 word, 2 long, 3 quad. A cycle with obs_quad=1 has size quad. Otherwise its size is obs_size, where obs_size=3 without obs_quad is no valid size and never matches. With bit 0 clear, size and data are ignored.
- R9: With data comparison enabled on a non-quad cycle, obs_data[31:0] must equal the match data on every bit whose data-mask bit is 0. Mask bits set to 1 are ignored.
- R10: On a quadword cycle with data comparison enabled, the data condition holds when obs_data[63:32] or obs_data[31:0] matches under the mask.
- R11: brk_req is 1 in exactly the clock after an obs_valid cycle that meets all conditions, and 0 otherwise. A cycle with obs_valid=0 never matches.
- R12: hit_flag rises together with brk_req and stays 1 until a write of bit 0 = 0 to the status register (index 5). Writing 1 there has no effect, and a new match in the same cycle as a clear keeps the flag set. Status bit 0 reads hit_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| obs_valid | input | 1 | A bus cycle is presented this clock |
| obs_fetch | input | 1 | 1 = instruction fetch, 0 = operand access |
| obs_write | input | 1 | 1 = write, 0 = read |
| obs_addr | input | 32 | Cycle address |
| obs_data | input | 64 | Cycle data; the upper half is used only on quadword cycles |
| obs_size | input | 2 | Operand size: 0 byte, 1 word, 2 long |
| obs_quad | input | 1 | Quadword access flag |
| brk_req | output | 1 | Registered break request |
| hit_flag | output | 1 | Sticky match flag |

## Verification
A bus cycle driven in one clock is latched at the next rising edge. Its break request is therefore due one full clock later, and the bench reads brk_req at the falling edge that ends the cycle it drove. At the following falling edge it checks that the pulse has ended. Register writes take effect at the edge that ends the write clock. Reads are combinational, so the bench reads them a short delay after setting the index at a falling edge. hit_flag is checked at the same point as brk_req, and again after each status write.

// File: rtl/brk_pkg.sv
// Package: shared types and register indices of the break match channel.
// Assumes a register index port of 3 bits.
package brk_pkg;
    typedef struct packed {
        logic [1:0] bus;    // bus select, 00 = operand bus
        logic [1:0] ctype;  // cycle-type select
        logic [1:0] rw;     // direction select
        logic       en;     // channel enable
    } ctrl_t;

    localparam logic [2:0] IDX_CTRL = 3'd0;
    localparam logic [2:0] IDX_ADDR = 3'd1;
    localparam logic [2:0] IDX_DATA = 3'd2;
    localparam logic [2:0] IDX_MASK = 3'd3;
    localparam logic [2:0] IDX_COND = 3'd4;
    localparam logic [2:0] IDX_STAT = 3'd5;

    localparam logic [1:0] CT_FETCH = 2'b01;
    localparam logic [1:0] CT_OPER  = 2'b10;
    localparam logic [1:0] RW_READ  = 2'b01;
    localparam logic [1:0] RW_WRITE = 2'b10;
    localparam logic [1:0] SZ_QUAD  = 2'b11;
endpackage

// File: rtl/brk_regs.sv
// Register file: holds the control word, match address, match data, data mask,
// data-condition word and the sticky match flag. Reads are combinational.
// Assumes AW and DW do not exceed RW.
module brk_regs
    import brk_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int RW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [RW-1:0] reg_wdata,
    output logic [RW-1:0] reg_rdata,
    input  logic          set_hit,
    output ctrl_t         ctrl_q,
    output logic [AW-1:0] maddr_q,
    output logic [DW-1:0] mdata_q,
    output logic [DW-1:0] mmask_q,
    output logic          den_q,
    output logic [1:0]    dsize_q,
    output logic          hit_q
);
    logic clr_hit;

    // Decode a clearing write to the status register.
    assign clr_hit = reg_wr && (reg_addr == IDX_STAT) && !reg_wdata[0];

    // Configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            maddr_q <= '0;
            mdata_q <= '0;
            mmask_q <= '0;
            den_q   <= 1'b0;
            dsize_q <= 2'b00;
        end else if (reg_wr) begin
            case (reg_addr)
                IDX_CTRL: ctrl_q  <= '{bus: reg_wdata[7:6], ctype: reg_wdata[5:4],
                                       rw: reg_wdata[2:1], en: reg_wdata[0]};
                IDX_ADDR: maddr_q <= reg_wdata[AW-1:0];
                IDX_DATA: mdata_q <= reg_wdata[DW-1:0];
                IDX_MASK: mmask_q <= reg_wdata[DW-1:0];
                IDX_COND: begin
                    den_q   <= reg_wdata[0];
                    dsize_q <= reg_wdata[2:1];
                end
                default: ;
            endcase
        end
    end

    // Sticky flag: a new match wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       hit_q <= 1'b0;
        else if (set_hit) hit_q <= 1'b1;
        else if (clr_hit) hit_q <= 1'b0;
    end

    // Read multiplexer; reserved bits read as zero.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            IDX_CTRL: reg_rdata[7:0] = {ctrl_q.bus, ctrl_q.ctype, 1'b0, ctrl_q.rw, ctrl_q.en};
            IDX_ADDR: reg_rdata[AW-1:0] = maddr_q;
            IDX_DATA: reg_rdata[DW-1:0] = mdata_q;
            IDX_MASK: reg_rdata[DW-1:0] = mmask_q;
            IDX_COND: reg_rdata[2:0] = {dsize_q, den_q};
            IDX_STAT: reg_rdata[0] = hit_q;
            default: ;
        endcase
    end
endmodule

// File: rtl/brk_qual.sv
// Cycle qualifier: decides whether a cycle's type, direction and bus satisfy
// the control word. Direction and bus apply only under operand-only selection.
module brk_qual
    import brk_pkg::*;
(
    input  ctrl_t ctrl,
    input  logic  obs_fetch,
    input  logic  obs_write,
    output logic  qual_ok
);
    logic rw_ok;

    // Direction decode; 00 and 11 accept both directions.
    always_comb begin
        case (ctrl.rw)
            RW_READ:  rw_ok = !obs_write;
            RW_WRITE: rw_ok = obs_write;
            default:  rw_ok = 1'b1;
        endcase
    end

    // Cycle-type decode, with bus and direction gated by operand-only selection.
    always_comb begin
        case (ctrl.ctype)
            CT_FETCH: qual_ok = obs_fetch;
            CT_OPER:  qual_ok = !obs_fetch && (ctrl.bus == 2'b00) && rw_ok;
            default:  qual_ok = 1'b1;
        endcase
    end
endmodule

// File: rtl/brk_cmp.sv
// Address and data comparator: exact address match, operand size check and a
// masked data compare applied to each half of the data bus. A quadword cycle
// matches on either half; other cycles use the low half only.
module brk_cmp
    import brk_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic [AW-1:0]   maddr,
    input  logic [DW-1:0]   mdata,
    input  logic [DW-1:0]   mmask,
    input  logic            den,
    input  logic [1:0]      dsize,
    input  logic [AW-1:0]   obs_addr,
    input  logic [2*DW-1:0] obs_data,
    input  logic [1:0]      obs_size,
    input  logic            obs_quad,
    output logic            cmp_ok
);
    localparam int NHALF = 2;

    logic [NHALF-1:0] half_hit;
    logic             size_ok;
    logic             data_ok;

    // One masked comparator per data half.
    for (genvar h = 0; h < NHALF; h++) begin : g_half
        assign half_hit[h] = (((obs_data[h*DW +: DW] ^ mdata) & ~mmask) == '0);
    end

    // Size and data condition combination.
    always_comb begin
        if (obs_quad) size_ok = (dsize == SZ_QUAD);
        else          size_ok = (obs_size == dsize) && (obs_size != SZ_QUAD);
        data_ok = obs_quad ? (|half_hit) : half_hit[0];
        cmp_ok  = (obs_addr == maddr) && (!den || (size_ok && data_ok));
    end
endmodule

// File: rtl/brk_match_chan.sv
// Top of the break match channel: registers, qualifier and comparator, plus
// the registered break request. Synchronous active-low reset.
module brk_match_chan
    import brk_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    localparam int RW = (AW > DW) ? AW : DW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [2:0]      reg_addr,
    input  logic [RW-1:0]   reg_wdata,
    output logic [RW-1:0]   reg_rdata,
    input  logic            obs_valid,
    input  logic            obs_fetch,
    input  logic            obs_write,
    input  logic [AW-1:0]   obs_addr,
    input  logic [2*DW-1:0] obs_data,
    input  logic [1:0]      obs_size,
    input  logic            obs_quad,
    output logic            brk_req,
    output logic            hit_flag
);
    ctrl_t         ctrl_q;
    logic [AW-1:0] maddr_q;
    logic [DW-1:0] mdata_q;
    logic [DW-1:0] mmask_q;
    logic          den_q;
    logic [1:0]    dsize_q;
    logic          qual_ok;
    logic          cmp_ok;
    logic          match;

    brk_regs #(.AW(AW), .DW(DW), .RW(RW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .set_hit(match),
        .ctrl_q(ctrl_q), .maddr_q(maddr_q), .mdata_q(mdata_q), .mmask_q(mmask_q),
        .den_q(den_q), .dsize_q(dsize_q), .hit_q(hit_flag)
    );

    brk_qual u_qual (
        .ctrl(ctrl_q), .obs_fetch(obs_fetch), .obs_write(obs_write), .qual_ok(qual_ok)
    );

    brk_cmp #(.AW(AW), .DW(DW)) u_cmp (
        .maddr(maddr_q), .mdata(mdata_q), .mmask(mmask_q), .den(den_q), .dsize(dsize_q),
        .obs_addr(obs_addr), .obs_data(obs_data), .obs_size(obs_size),
        .obs_quad(obs_quad), .cmp_ok(cmp_ok)
    );

    // A match needs a valid cycle, an enabled channel and both condition groups.
    assign match = obs_valid && ctrl_q.en && qual_ok && cmp_ok;

    // Register the break request one clock after the matching cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) brk_req <= 1'b0;
        else        brk_req <= match;
    end
endmodule

// File: rtl/brk_match_chan_chk.sv
// Checker for the break match channel, bound to the top module.
module brk_match_chan_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        obs_valid,
    input logic        en,
    input logic        qual_ok,
    input logic        cmp_ok,
    input logic        reg_wr,
    input logic [2:0]  reg_addr,
    input logic        wdata0,
    input logic [31:0] reg_rdata,
    input logic        brk_req,
    input logic        hit_flag
);
    // R3: a disabled channel never requests a break
    a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !brk_req);

    // R11: a qualified valid cycle requests a break one clock later
    a_r11_break_next: assert property (@(posedge clk) disable iff (!rst_n)
        (obs_valid && en && qual_ok && cmp_ok) |=> brk_req);

    // R11: no break without a qualified valid cycle in the previous clock
    a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(obs_valid && en && qual_ok && cmp_ok) |=> !brk_req);

    // R12: the flag is set whenever a break is requested
    a_r12_flag_with_break: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> hit_flag);

    // R12: the flag holds unless a clearing status write occurs
    a_r12_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_flag && !(reg_wr && reg_addr == 3'd5 && !wdata0)) |=> hit_flag);

    // R2: the reserved control bit always reads 0
    a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 3'd0) |-> (reg_rdata[3] == 1'b0));
endmodule

bind brk_match_chan brk_match_chan_chk u_chk (
    .clk(clk), .rst_n(rst_n), .obs_valid(obs_valid), .en(ctrl_q.en),
    .qual_ok(qual_ok), .cmp_ok(cmp_ok), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .wdata0(reg_wdata[0]), .reg_rdata(reg_rdata), .brk_req(brk_req), .hit_flag(hit_flag)
);

// File: tb/brk_match_chan_test.sv
// Bench for the break match channel: sweeps of the qualifier fields and of
// size, mask and data patterns, with expected results computed here.
module brk_match_chan_test;
    localparam int PERIOD = 10;
    localparam logic [31:0] MADDR = 32'h0000_1A40;
    localparam logic [31:0] MDATA = 32'hA5C3_0F1E;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        obs_valid = 1'b0;
    logic        obs_fetch = 1'b0;
    logic        obs_write = 1'b0;
    logic [31:0] obs_addr = '0;
    logic [63:0] obs_data = '0;
    logic [1:0]  obs_size = 2'd0;
    logic        obs_quad = 1'b0;
    logic        brk_req;
    logic        hit_flag;

    int n_chk = 0;
    int n_bad = 0;

    brk_match_chan uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .obs_valid(obs_valid),
        .obs_fetch(obs_fetch), .obs_write(obs_write), .obs_addr(obs_addr),
        .obs_data(obs_data), .obs_size(obs_size), .obs_quad(obs_quad),
        .brk_req(brk_req), .hit_flag(hit_flag)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // Present one cycle; returns brk_req one clock later and checks it ends next clock.
    task automatic bus(input logic f, input logic w, input logic [31:0] a,
                       input logic [63:0] d, input logic [1:0] sz, input logic q,
                       input string req, input logic exp);
        @(negedge clk);
        obs_valid = 1'b1; obs_fetch = f; obs_write = w; obs_addr = a;
        obs_data = d; obs_size = sz; obs_quad = q;
        @(negedge clk);
        obs_valid = 1'b0;
        check(req, {63'd0, brk_req}, {63'd0, exp});
        @(negedge clk);
        check("R11 pulse ends", {63'd0, brk_req}, 64'd0);
    endtask

    function automatic logic half_ok(input logic [31:0] d, input logic [31:0] mk);
        return ((d ^ MDATA) & ~mk) == 32'd0;
    endfunction

    initial begin
        #(PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 brk_req", {63'd0, brk_req}, 64'd0);
        check("R1 hit_flag", {63'd0, hit_flag}, 64'd0);
        for (int i = 0; i < 6; i++) begin
            rd(i[2:0], r);
            check("R1 register zero", {32'd0, r}, 64'd0);
        end
        // R2: control layout and read-back
        wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, r);
        check("R2 ctrl reserved bits", {32'd0, r}, 64'h0000_00F7);
        wr(3'd4, 32'hFFFF_FFFF); rd(3'd4, r);
        check("R2 cond readback", {32'd0, r}, 64'h7);
        wr(3'd3, 32'h1234_5678); rd(3'd3, r);
        check("R2 mask readback", {32'd0, r}, 64'h1234_5678);
        wr(3'd2, MDATA); rd(3'd2, r);
        check("R2 data readback", {32'd0, r}, {32'd0, MDATA});
        wr(3'd1, MADDR); rd(3'd1, r);
        check("R2 addr readback", {32'd0, r}, {32'd0, MADDR});
        wr(3'd4, 32'd0);
        // R3: disabled channel, all other fields set to accept everything
        wr(3'd0, 32'h0000_0000);
        for (int k = 0; k < 4; k++)
            bus(k[0], k[1], MADDR, 64'd0, 2'd0, 1'b0, "R3 disabled", 1'b0);
        // R4 R5 R6: qualifier sweep
        for (int ct = 0; ct < 4; ct++)
            for (int bs = 0; bs < 4; bs++)
                for (int rw = 0; rw < 4; rw++) begin
                    wr(3'd0, {24'd0, bs[1:0], ct[1:0], 1'b0, rw[1:0], 1'b1});
                    for (int k = 0; k < 4; k++) begin
                        logic f, w;
                        f = k[0]; w = k[1];
                        if (ct == 1)      e = f;
                        else if (ct == 2) e = !f && (bs == 0) &&
                                              ((rw == 1) ? !w : (rw == 2) ? w : 1'b1);
                        else              e = 1'b1;
                        bus(f, w, MADDR, 64'd0, 2'd0, 1'b0, "R4 R5 R6 qualifier", e);
                    end
                end
        // R7: address must match on every bit
        wr(3'd0, 32'h0000_0001);
        bus(1'b1, 1'b0, MADDR ^ 32'h1, 64'd0, 2'd0, 1'b0, "R7 addr lsb", 1'b0);
        bus(1'b0, 1'b1, MADDR ^ 32'h8000_0000, 64'd0, 2'd0, 1'b0, "R7 addr msb", 1'b0);
        bus(1'b0, 1'b1, MADDR, 64'd0, 2'd0, 1'b0, "R7 addr equal", 1'b1);
        // R11: invalid cycle never matches
        @(negedge clk);
        obs_valid = 1'b0; obs_addr = MADDR;
        @(negedge clk);
        check("R11 no valid", {63'd0, brk_req}, 64'd0);
        // R8 R9 R10: size, mask and data sweep on operand cycles
        wr(3'd0, 32'h0000_0021);
        for (int mi = 0; mi < 3; mi++) begin
            logic [31:0] mk;
            mk = (mi == 0) ? 32'd0 : (mi == 1) ? 32'h0000_01FF : 32'hFFFF_FFFF;
            wr(3'd3, mk);
            for (int cs = 0; cs < 4; cs++) begin
                wr(3'd4, {29'd0, cs[1:0], 1'b1});
                for (int os = 0; os < 5; os++)
                    for (int lo = 0; lo < 3; lo++)
                        for (int hi = 0; hi < 2; hi++) begin
                            logic [31:0] dl, dh;
                            logic q, sz_ok, d_ok;
                            q = (os == 4);
                            dl = (lo == 0) ? MDATA : (lo == 1) ? MDATA ^ 32'h100 : MDATA ^ 32'h4000_0000;
                            dh = (hi == 0) ? MDATA : ~MDATA;
                            sz_ok = q ? (cs == 3) : ((os == cs) && (os != 3));
                            d_ok  = q ? (half_ok(dl, mk) || half_ok(dh, mk)) : half_ok(dl, mk);
                            bus(1'b0, 1'b0, MADDR, {dh, dl}, os[1:0], q,
                                "R8 R9 R10 data", sz_ok && d_ok);
                        end
            end
        end
        // R8: data comparison off ignores size and data
        wr(3'd4, 32'd6);
        bus(1'b0, 1'b0, MADDR, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b0, "R8 data off", 1'b1);
        // R12: sticky flag behaviour
        wr(3'd5, 32'd0); rd(3'd5, r);
        check("R12 cleared", {32'd0, r}, 64'd0);
        bus(1'b0, 1'b0, MADDR, 64'd0, 2'd0, 1'b0, "R12 set match", 1'b1);
        check("R12 flag set", {63'd0, hit_flag}, 64'd1);
        bus(1'b0, 1'b0, MADDR ^ 32'h4, 64'd0, 2'd0, 1'b0, "R12 miss", 1'b0);
        check("R12 flag holds", {63'd0, hit_flag}, 64'd1);
        wr(3'd5, 32'd1);
        check("R12 write one", {63'd0, hit_flag}, 64'd1);
        wr(3'd5, 32'd0);
        check("R12 write zero", {63'd0, hit_flag}, 64'd0);
        // R12: match and clear in the same cycle keeps the flag
        @(negedge clk);
        obs_valid = 1'b1; obs_fetch = 1'b0; obs_addr = MADDR;
        reg_wr = 1'b1; reg_addr = 3'd5; reg_wdata = 32'd0;
        @(negedge clk);
        obs_valid = 1'b0; reg_wr = 1'b0;
        check("R12 set wins", {63'd0, hit_flag}, 64'd1);
        rd(3'd5, r);
        check("R12 status read", {32'd0, r}, 64'd1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule